// File: doc/BRIEF.md
# Two-Wire Bus Byte Shift Register

This block is the data path of a two-wire serial bus port. One byte-wide register serves both directions. When transmitting, it presents its most significant bit on the data line and, on every clock-high strobe, shifts in the level the line actually carried. After eight bits it therefore holds the byte that was seen on the wire, whichever side pulled the line low. When receiving, the same shifting fills the register with the incoming byte. A ninth clock carries the acknowledge. Internal logic drives or samples that acknowledge, and it never reaches the data register.

A completion flag sets when the ninth clock ends. While the flag is set the shifter is idle, the register is frozen, and the CPU may read it or load the next byte. A write made while a byte is in flight is dropped and raises a collision bit. The protocol controller outside this block supplies a byte-start pulse, the transfer direction, the clock edge strobes and an arbitration-loss pulse. If arbitration is lost, the block stops driving the line and finishes the byte as a receiver, keeping every bit it has already captured.

The data line is open-drain: `sda_pull` high means the block pulls the line low, and the bus level returned on `sda_in` is the wired-AND of all drivers.

Top module: `twb_byte_shifter`

## Requirements
- R1: After reset `cpu_rdata` is 0xFF, and `irq_flag`, `wcol`, `sda_pull` and `ack_seen` are all 0.
- R2: A `cpu_we` pulse while `irq_flag` is 1 loads `cpu_wdata` into the register, so it appears on `cpu_rdata` after one clock, and clears `wcol`.
- R3: A `cpu_we` pulse while `irq_flag` is 0 leaves `cpu_rdata` unchanged and sets `wcol` to 1 on the next clock.
- R4: While `irq_flag` is 1, `cpu_rdata` changes only through an accepted CPU write. `byte_start` and the SCL strobes are ignored, and `sda_pull` stays 0.
- R5: A byte starts on a `byte_start` pulse while `irq_flag` is 0. In transmit (`tx_mode`=1), data bits go out MSB first. `sda_pull` equals the inverse of the current bit and takes its first value one clock after `byte_start`. Each later bit appears one clock after the `scl_fall` that ends the previous bit.
- R6: On each of the eight data-bit `scl_rise` strobes, the register shifts left by one and takes the `sda_in` level into bit 0. After the byte it holds the bus byte, which in transmit is the wired-AND of the sent byte and any other driver.
- R7: On the ninth clock, a receiver (`tx_mode`=0 or after arbitration loss) sets `sda_pull` to `ack_en`. A transmitter releases the line and, on that clock's `scl_rise`, sets `ack_seen` to the inverse of `sda_in`. The acknowledge level never enters `cpu_rdata`.
- R8: `irq_flag` becomes 1 one clock after the `scl_fall` that ends the ninth clock. It returns to 0 one clock after a `flag_clr` pulse.
- R9: An `arb_lost` pulse during a byte sets `sda_pull` to 0 on the next clock and keeps it 0 for the remaining data bits. Bits already captured are kept, and the byte completes as a receive, including the receiver acknowledge of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one clock |
| cpu_rdata | output | 8 | Register read-back |
| flag_clr | input | 1 | Clears the completion flag |
| irq_flag | output | 1 | Byte complete, register frozen |
| wcol | output | 1 | Write collision status |
| tx_mode | input | 1 | 1 transmit, 0 receive; sampled at byte start |
| ack_en | input | 1 | Receiver acknowledges (pulls low) on ninth clock |
| ack_seen | output | 1 | Transmitter saw acknowledge (line low) |
| byte_start | input | 1 | Begin shifting a byte |
| arb_lost | input | 1 | Arbitration lost pulse |
| scl_rise | input | 1 | SCL rising-edge strobe |
| scl_fall | input | 1 | SCL falling-edge strobe |
| sda_in | input | 1 | Sampled bus data level |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The assertions take for granted that the strobes `scl_rise`, `scl_fall`, `arb_lost` and `byte_start` are single-clock pulses that never share a clock. They also take for granted that `flag_clr` arrives only while no byte is in flight. The stimulus keeps within this by driving each strobe in its own two-clock slot from one sequential task. It raises `arb_lost` only between a rise and a fall strobe, at the first bit where the other driver pulls low against a sent 1. It clears the flag only after the completion flag has been observed.

// File: rtl/twb_pkg.sv
package twb_pkg;
    typedef struct packed {
        logic flag;
        logic wcol;
        logic ack_seen;
        logic role_tx;
        logic out_low;
    } twb_ctrl_t;
endpackage

// File: rtl/twb_bit_counter.sv
module twb_bit_counter #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic scl_fall,
    output logic busy,
    output logic in_ack,
    output logic last_data,
    output logic done
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (scl_fall && st_q.busy) begin
            if (st_q.cnt == CNT_W'(DATA_W)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign in_ack    = st_q.busy && (st_q.cnt == CNT_W'(DATA_W));
    assign last_data = st_q.busy && (st_q.cnt == CNT_W'(DATA_W - 1));
    assign done      = scl_fall && in_ack;
endmodule

// File: rtl/twb_shift_reg.sv
module twb_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    input  logic              sda_in,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load)       data_d = load_data;
        else if (shift) data_d = {data_q[DATA_W-2:0], sda_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '1;
        else        data_q <= data_d;
    end

    assign data = data_q;
endmodule

// File: rtl/twb_byte_shifter.sv
module twb_byte_shifter
    import twb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              flag_clr,
    output logic              irq_flag,
    output logic              wcol,
    input  logic              tx_mode,
    input  logic              ack_en,
    output logic              ack_seen,
    input  logic              byte_start,
    input  logic              arb_lost,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    output logic              sda_pull
);
    twb_ctrl_t ctrl_d, ctrl_q;

    logic              busy, in_ack, last_data, done;
    logic              start_ok, shift_en, wr_ok;
    logic [DATA_W-1:0] data;

    assign start_ok = byte_start && !busy && !ctrl_q.flag;
    assign shift_en = scl_rise && busy && !in_ack;
    assign wr_ok    = cpu_we && ctrl_q.flag;

    twb_bit_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_ok),
        .scl_fall  (scl_fall),
        .busy      (busy),
        .in_ack    (in_ack),
        .last_data (last_data),
        .done      (done)
    );

    twb_shift_reg #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_ok),
        .load_data (cpu_wdata),
        .shift     (shift_en),
        .sda_in    (sda_in),
        .data      (data)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (cpu_we) ctrl_d.wcol = !ctrl_q.flag;
        if (flag_clr) ctrl_d.flag = 1'b0;
        if (done) ctrl_d.flag = 1'b1;
        if (start_ok) begin
            ctrl_d.role_tx = tx_mode;
            ctrl_d.out_low = tx_mode && !data[DATA_W-1];
        end
        if (scl_rise && in_ack && ctrl_q.role_tx) ctrl_d.ack_seen = !sda_in;
        if (scl_fall && busy) begin
            if (done)           ctrl_d.out_low = 1'b0;
            else if (last_data) ctrl_d.out_low = !ctrl_q.role_tx && ack_en;
            else                ctrl_d.out_low = ctrl_q.role_tx && !data[DATA_W-1];
        end
        if (arb_lost && busy) begin
            ctrl_d.role_tx = 1'b0;
            ctrl_d.out_low = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign cpu_rdata = data;
    assign irq_flag  = ctrl_q.flag;
    assign wcol      = ctrl_q.wcol;
    assign ack_seen  = ctrl_q.ack_seen;
    assign sda_pull  = ctrl_q.out_low;
endmodule

// File: rtl/twb_byte_shifter_chk.sv
module twb_byte_shifter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_we,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              flag_clr,
    input logic              irq_flag,
    input logic              wcol,
    input logic              arb_lost,
    input logic              scl_fall,
    input logic              sda_pull
);
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && cpu_we) |=> (cpu_rdata == $past(cpu_wdata)) && !wcol); // R2

    AST_BUSY_WRITE_COLLIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flag && cpu_we) |=> (wcol && $stable(cpu_rdata))); // R3

    AST_FROZEN_WHILE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !cpu_we) |=> $stable(cpu_rdata)); // R4

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |-> !sda_pull); // R4

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && irq_flag) |=> !irq_flag); // R8

    AST_ARB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !scl_fall) |=> !sda_pull); // R9
endmodule

bind twb_byte_shifter twb_byte_shifter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .cpu_rdata (cpu_rdata),
    .flag_clr  (flag_clr),
    .irq_flag  (irq_flag),
    .wcol      (wcol),
    .arb_lost  (arb_lost),
    .scl_fall  (scl_fall),
    .sda_pull  (sda_pull)
);

// File: tb/twb_byte_shifter_tb.sv
module twb_byte_shifter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_rdata;
    logic       flag_clr = 1'b0;
    logic       irq_flag, wcol, ack_seen, sda_pull;
    logic       tx_mode = 1'b0, ack_en = 1'b0;
    logic       byte_start = 1'b0, arb_lost = 1'b0;
    logic       scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    twb_byte_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .cpu_rdata(cpu_rdata), .flag_clr(flag_clr), .irq_flag(irq_flag),
        .wcol(wcol), .tx_mode(tx_mode), .ack_en(ack_en), .ack_seen(ack_seen),
        .byte_start(byte_start), .arb_lost(arb_lost), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .sda_in(sda_in), .sda_pull(sda_pull)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rise();
        @(negedge clk) scl_rise = 1'b1;
        @(negedge clk) scl_rise = 1'b0;
    endtask

    task automatic pulse_fall();
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
    endtask

    task automatic cpu_write(input logic [7:0] v);
        @(negedge clk) begin cpu_wdata = v; cpu_we = 1'b1; end
        @(negedge clk) cpu_we = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk("R8 flag clear", {7'd0, irq_flag}, 8'd0);
    endtask

    // The first bit at which the other driver pulls low against a sent 1; -1 if none.
    function automatic int lose_bit(input logic [7:0] txb, input logic [7:0] oth);
        for (int i = 7; i >= 0; i--) if (txb[i] && !oth[i]) return i;
        return -1;
    endfunction

    // The byte seen on the wire: wired-AND while driving, the other side alone after a loss.
    function automatic logic [7:0] bus_byte(input logic tx, input logic [7:0] txb,
                                            input logic [7:0] oth, input int lp);
        logic [7:0] r;
        logic lost;
        lost = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            r[i] = oth[i] & ~(tx && !lost && !txb[i]);
            if (i == lp) lost = 1'b1;
        end
        return r;
    endfunction

    task automatic run_byte(input logic do_wr, input logic tx, input logic [7:0] txb,
                            input logic [7:0] oth, input logic aen, input logic oth_ack,
                            input logic try_lose, input logic mid_wr);
        int lp;
        logic lost, exp_low;
        logic [7:0] exp_byte;
        if (do_wr) begin
            cpu_write(txb);
            chk("R2 write accepted", cpu_rdata, txb);
            chk("R2 wcol cleared", {7'd0, wcol}, 8'd0);
        end
        clear_flag();
        lp = (tx && try_lose) ? lose_bit(txb, oth) : -1;
        exp_byte = bus_byte(tx, txb, oth, lp);
        lost = 1'b0;
        @(negedge clk) begin tx_mode = tx; ack_en = aen; byte_start = 1'b1; end
        @(negedge clk) byte_start = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            exp_low = tx && !lost && !txb[i];
            chk(lost ? "R9 released after loss" : "R5 bit drive", {7'd0, sda_pull}, {7'd0, exp_low});
            sda_in = oth[i] & !exp_low;
            pulse_rise();
            if (i == lp) begin
                @(negedge clk) arb_lost = 1'b1;
                @(negedge clk) arb_lost = 1'b0;
                chk("R9 release on loss", {7'd0, sda_pull}, 8'd0);
                lost = 1'b1;
            end
            if (mid_wr && i == 4) begin
                cpu_write(~txb);
                chk("R3 collision flagged", {7'd0, wcol}, 8'd1);
            end
            pulse_fall();
        end
        if (tx && !lost) begin
            chk("R7 transmitter releases on ack", {7'd0, sda_pull}, 8'd0);
            sda_in = !oth_ack;
        end else begin
            chk("R7 receiver ack drive", {7'd0, sda_pull}, {7'd0, aen});
            sda_in = !aen;
        end
        pulse_rise();
        chk("R8 no flag before ninth fall", {7'd0, irq_flag}, 8'd0);
        pulse_fall();
        chk("R8 flag after ninth clock", {7'd0, irq_flag}, 8'd1);
        chk("R6 bus byte captured, ack excluded", cpu_rdata, exp_byte);
        chk("R4 line released when done", {7'd0, sda_pull}, 8'd0);
        if (tx && !lost) chk("R7 ack sampled", {7'd0, ack_seen}, {7'd0, oth_ack});
        if (mid_wr) chk("R3 collision persists", {7'd0, wcol}, 8'd1);
        sda_in = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] snap;
        void'($urandom(32'd20240611));
        idle(3);
        chk("R1 reset data", cpu_rdata, 8'hFF);
        chk("R1 reset status", {4'd0, irq_flag, wcol, sda_pull, ack_seen}, 8'd0);
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        cpu_write(8'h3C);
        chk("R3 write ignored while flag clear", cpu_rdata, 8'hFF);
        chk("R3 wcol set", {7'd0, wcol}, 8'd1);
        // first byte shifts the reset content, other side pulls some bits low
        run_byte(1'b0, 1'b1, 8'hFF, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0);
        // frozen while flag set: strobes ignored
        snap = cpu_rdata;
        sda_in = 1'b0;
        @(negedge clk) byte_start = 1'b1;
        @(negedge clk) byte_start = 1'b0;
        pulse_rise();
        pulse_fall();
        chk("R4 data frozen", cpu_rdata, snap);
        chk("R4 no drive while flag", {7'd0, sda_pull}, 8'd0);
        chk("R4 flag held", {7'd0, irq_flag}, 8'd1);
        sda_in = 1'b1;
        // directed: transmit with collision, receive with and without ack, forced loss
        run_byte(1'b1, 1'b1, 8'h96, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
        run_byte(1'b1, 1'b0, 8'h00, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0);
        run_byte(1'b1, 1'b0, 8'hFF, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0);
        run_byte(1'b1, 1'b1, 8'hF0, 8'hB7, 1'b1, 1'b1, 1'b1, 1'b0);
        run_byte(1'b1, 1'b1, 8'h01, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 60; k++) begin
            logic [31:0] r;
            r = $urandom;
            run_byte(1'b1, r[0], r[15:8], (r[1] ? 8'hFF : r[23:16]), r[2], r[3],
                     r[4], (r[7:5] == 3'd0));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule